// File: doc/BRIEF.md
# String Header Scan Dispatcher

This block sits at the front of a ring of processing elements. Each processing element runs one instruction string. Every cycle the block can take a window of eight fixed-size 16-bit string headers. For every slot of the window it works out where that slot's instruction body begins, measured in instruction units from the end of the header block. It also works out which piece of architectural state the string will update: a destination register, a memory location whose address is not yet known, or the program counter with a target that is not yet known.

A slot's body offset is the total of the body lengths of all headers that come before it in the window. The block forms these totals with a log-depth parallel prefix adder, not a ripple chain. Slot 0 always starts at offset zero, so its decoded update set is available combinationally in the cycle the window is presented. The complete bundle for all slots is registered and appears one cycle after the window is accepted. A header with a zero length field ends the hyperblock: that slot and every slot after it are reported empty.

Input and output both use valid/ready handshakes. A new window is accepted only when the output register is empty, or when its contents are being consumed in the same cycle.

Top module: `hdr_scan_dispatch`

## Requirements
- R1: Header layout per slot i (bits [16i+15:16i] of the window): body length in bits [15:10], memory-update flag in bit 9, program-counter-update flag in bit 8, register-write flag in bit 7, register number in bits [4:0]. For a live slot, the flags appear unchanged on the per-slot outputs out_mem_upd, out_pc_upd and out_reg_we.
- R2: For a live slot k, out_offset field k (bits [9k+8:9k]) equals the sum of the length fields of slots 0..k-1. Slot 0 is always 0. Seven lengths of 63 give 441, with no overflow.
- R3: A zero length field in slot k makes slots k..7 not live. Their out_slot_valid bits are 0, and their offset, flags and register number are all 0. The live slots always form a run starting at slot 0.
- R4: out_reg_num field k (bits [5k+4:5k]) carries the register number only when slot k is live and its register-write flag is 1; otherwise it is 0.
- R5: Header bits [6:5] are reserved and have no effect on any output.
- R6: The lead outputs (lead_valid, lead_reg_we, lead_reg_num, lead_mem_upd, lead_pc_upd) decode slot 0 of in_window combinationally in the same cycle. lead_valid is 1 only when in_valid is 1 and slot 0's length is nonzero. When lead_valid is 0, all the other lead outputs are 0.
- R7: A window accepted at a clock edge (in_valid and in_ready both 1) appears on the registered bundle with out_valid at 1 right after that edge.
- R8: in_ready is 1 exactly when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, the bundle holds stable and no window is accepted.
- R9: While reset is held, out_valid is 0 and in_ready is 1.
- R10: With out_ready held at 1, one window can be accepted on every clock edge. Each window's bundle appears in order, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A header window is offered |
| in_ready | output | 1 | The block can take a window this cycle |
| in_window | input | 128 | Eight 16-bit headers, slot i in bits [16i+15:16i] |
| lead_valid | output | 1 | Slot 0 of the offered window is live (same cycle) |
| lead_reg_we | output | 1 | Slot 0 register-write flag (same cycle) |
| lead_reg_num | output | 5 | Slot 0 destination register (same cycle) |
| lead_mem_upd | output | 1 | Slot 0 memory-update flag (same cycle) |
| lead_pc_upd | output | 1 | Slot 0 program-counter-update flag (same cycle) |
| out_valid | output | 1 | The registered bundle holds a window |
| out_ready | input | 1 | The consumer takes the bundle this cycle |
| out_slot_valid | output | 8 | Per-slot live flag |
| out_offset | output | 72 | Per-slot 9-bit body offset |
| out_reg_we | output | 8 | Per-slot register-write flag |
| out_reg_num | output | 40 | Per-slot 5-bit register number |
| out_mem_upd | output | 8 | Per-slot memory-update flag |
| out_pc_upd | output | 8 | Per-slot program-counter-update flag |

## Verification
The bench targets the cases where the sums are largest and where the window is cut short. With every length at 63, a prefix adder that is too narrow or misaligned would wrap or skew the upper offsets. Terminators are placed in slot 0, in the middle and in the last slot. A mask that leaks would show live flags or offsets after the terminator, and a mask that is shifted by one would kill the terminator's neighbour. Reserved bits are set to catch a decoder that reads the wrong field. Stalls and back-to-back windows are run to catch a bundle that changes while stalled, a window that is lost or taken twice, and any loss of single-cycle throughput.

// File: rtl/hdr_scan_pkg.sv
package hdr_scan_pkg;

   localparam int HDR_W   = 16;
   localparam int LEN_W   = 6;
   localparam int REG_W   = 5;

   localparam int LEN_MSB = 15;
   localparam int LEN_LSB = 10;
   localparam int MEM_BIT = 9;
   localparam int PC_BIT  = 8;
   localparam int RWE_BIT = 7;
   localparam int RSV_MSB = 6;
   localparam int RSV_LSB = 5;
   localparam int REG_MSB = 4;
   localparam int REG_LSB = 0;

   localparam int PREFIX_KOGGE_STONE = 0;
   localparam int PREFIX_SKLANSKY    = 1;

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic             mem;
      logic             pc;
      logic             rwe;
      logic [REG_W-1:0] rnum;
   } hdr_fields_t;

endpackage

// File: rtl/hdr_field_decode.sv
module hdr_field_decode
   import hdr_scan_pkg::*;
(
   input  logic [HDR_W-1:0] hdr,
   output hdr_fields_t      fields
);

   logic unused_rsvd;

   assign fields.len  = hdr[LEN_MSB:LEN_LSB];
   assign fields.mem  = hdr[MEM_BIT];
   assign fields.pc   = hdr[PC_BIT];
   assign fields.rwe  = hdr[RWE_BIT];
   assign fields.rnum = hdr[REG_MSB:REG_LSB];

   assign unused_rsvd = ^hdr[RSV_MSB:RSV_LSB];

endmodule

// File: rtl/hdr_term_mask.sv
module hdr_term_mask #(
   parameter int N = 8
) (
   input  logic [N-1:0] nonzero,
   output logic [N-1:0] alive
);

   always_comb begin
      logic run;
      run = 1'b1;
      for (int i = 0; i < N; i++) begin
         run      = run & nonzero[i];
         alive[i] = run;
      end
   end

endmodule

// File: rtl/hdr_prefix_sum.sv
module hdr_prefix_sum
   import hdr_scan_pkg::*;
#(
   parameter int N     = 8,
   parameter int IN_W  = 6,
   parameter int OUT_W = 9,
   parameter int KIND  = PREFIX_KOGGE_STONE
) (
   input  logic [N*IN_W-1:0]  lens,
   output logic [N*OUT_W-1:0] excl
);

   localparam int LEVELS = $clog2(N);

   logic [OUT_W-1:0] incl [N];

   if (KIND == PREFIX_KOGGE_STONE) begin : g_kogge
      always_comb begin
         logic [OUT_W-1:0] s [N];
         for (int i = 0; i < N; i++)
            s[i] = OUT_W'(lens[i*IN_W +: IN_W]);
         for (int l = 0; l < LEVELS; l++) begin
            for (int i = N - 1; i >= 0; i--) begin
               if (i >= (1 << l))
                  s[i] = s[i] + s[i - (1 << l)];
            end
         end
         for (int i = 0; i < N; i++)
            incl[i] = s[i];
      end
   end else begin : g_sklansky
      always_comb begin
         logic [OUT_W-1:0] s [N];
         for (int i = 0; i < N; i++)
            s[i] = OUT_W'(lens[i*IN_W +: IN_W]);
         for (int l = 0; l < LEVELS; l++) begin
            for (int i = 0; i < N; i++) begin
               if (((i >> l) & 1) == 1)
                  s[i] = s[i] + s[((i >> l) << l) - 1];
            end
         end
         for (int i = 0; i < N; i++)
            incl[i] = s[i];
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_excl
      if (i == 0) begin : g_first
         assign excl[0 +: OUT_W] = '0;
      end else begin : g_rest
         assign excl[i*OUT_W +: OUT_W] = incl[i-1];
      end
   end

endmodule

// File: rtl/hdr_scan_dispatch.sv
module hdr_scan_dispatch
   import hdr_scan_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int PREFIX_KIND = PREFIX_KOGGE_STONE,
   parameter int OFS_W       = LEN_W + $clog2(NUM_SLOTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [NUM_SLOTS*HDR_W-1:0] in_window,
   output logic                       lead_valid,
   output logic                       lead_reg_we,
   output logic [REG_W-1:0]           lead_reg_num,
   output logic                       lead_mem_upd,
   output logic                       lead_pc_upd,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [NUM_SLOTS-1:0]       out_slot_valid,
   output logic [NUM_SLOTS*OFS_W-1:0] out_offset,
   output logic [NUM_SLOTS-1:0]       out_reg_we,
   output logic [NUM_SLOTS*REG_W-1:0] out_reg_num,
   output logic [NUM_SLOTS-1:0]       out_mem_upd,
   output logic [NUM_SLOTS-1:0]       out_pc_upd
);

   localparam int MIN_OFS_W = LEN_W + $clog2(NUM_SLOTS);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("hdr_scan_dispatch: NUM_SLOTS must be at least 2");
   end
   if ((NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_pow2
      $error("hdr_scan_dispatch: NUM_SLOTS must be a power of two");
   end
   if (OFS_W < MIN_OFS_W) begin : g_bad_ofs
      $error("hdr_scan_dispatch: OFS_W too narrow for the worst-case sum");
   end
   if (PREFIX_KIND != PREFIX_KOGGE_STONE && PREFIX_KIND != PREFIX_SKLANSKY) begin : g_bad_kind
      $error("hdr_scan_dispatch: unknown PREFIX_KIND");
   end

   hdr_fields_t                fld [NUM_SLOTS];
   logic [NUM_SLOTS*LEN_W-1:0] len_flat;
   logic [NUM_SLOTS-1:0]       nonzero;
   logic [NUM_SLOTS-1:0]       alive;
   logic [NUM_SLOTS*OFS_W-1:0] excl;

   logic [NUM_SLOTS*OFS_W-1:0] nxt_ofs;
   logic [NUM_SLOTS-1:0]       nxt_we;
   logic [NUM_SLOTS*REG_W-1:0] nxt_rnum;
   logic [NUM_SLOTS-1:0]       nxt_mem;
   logic [NUM_SLOTS-1:0]       nxt_pc;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      hdr_field_decode u_dec (
         .hdr    (in_window[i*HDR_W +: HDR_W]),
         .fields (fld[i])
      );

      assign len_flat[i*LEN_W +: LEN_W] = fld[i].len;
      assign nonzero[i]                 = |fld[i].len;

      assign nxt_ofs[i*OFS_W +: OFS_W]  = alive[i] ? excl[i*OFS_W +: OFS_W] : '0;
      assign nxt_we[i]                  = alive[i] & fld[i].rwe;
      assign nxt_rnum[i*REG_W +: REG_W] = (alive[i] & fld[i].rwe) ? fld[i].rnum : '0;
      assign nxt_mem[i]                 = alive[i] & fld[i].mem;
      assign nxt_pc[i]                  = alive[i] & fld[i].pc;
   end

   hdr_term_mask #(
      .N (NUM_SLOTS)
   ) u_mask (
      .nonzero (nonzero),
      .alive   (alive)
   );

   hdr_prefix_sum #(
      .N     (NUM_SLOTS),
      .IN_W  (LEN_W),
      .OUT_W (OFS_W),
      .KIND  (PREFIX_KIND)
   ) u_sum (
      .lens (len_flat),
      .excl (excl)
   );

   // Lead slot: no register between window and these outputs
   assign lead_valid   = in_valid & alive[0];
   assign lead_reg_we  = lead_valid & fld[0].rwe;
   assign lead_reg_num = (lead_valid & fld[0].rwe) ? fld[0].rnum : '0;
   assign lead_mem_upd = lead_valid & fld[0].mem;
   assign lead_pc_upd  = lead_valid & fld[0].pc;

   logic accept;
   assign in_ready = ~out_valid | out_ready;
   assign accept   = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_slot_valid <= '0;
         out_offset     <= '0;
         out_reg_we     <= '0;
         out_reg_num    <= '0;
         out_mem_upd    <= '0;
         out_pc_upd     <= '0;
      end else if (accept) begin
         out_valid      <= 1'b1;
         out_slot_valid <= alive;
         out_offset     <= nxt_ofs;
         out_reg_we     <= nxt_we;
         out_reg_num    <= nxt_rnum;
         out_mem_upd    <= nxt_mem;
         out_pc_upd     <= nxt_pc;
      end else if (out_ready) begin
         out_valid      <= 1'b0;
      end
   end

endmodule

// File: rtl/hdr_scan_checker.sv
module hdr_scan_checker
   import hdr_scan_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int OFS_W     = 9
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic                       in_ready,
   input logic                       lead_valid,
   input logic                       out_valid,
   input logic                       out_ready,
   input logic [NUM_SLOTS-1:0]       out_slot_valid,
   input logic [NUM_SLOTS*OFS_W-1:0] out_offset,
   input logic [NUM_SLOTS-1:0]       out_reg_we,
   input logic [NUM_SLOTS*REG_W-1:0] out_reg_num,
   input logic [NUM_SLOTS-1:0]       out_mem_upd,
   input logic [NUM_SLOTS-1:0]       out_pc_upd
);

   logic [NUM_SLOTS-1:0] valid_plus;
   assign valid_plus = out_slot_valid + NUM_SLOTS'(1);

   assert_lead_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lead_valid |-> in_valid);

   assert_accept_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_offset)
                                     && $stable(out_slot_valid) && $stable(out_reg_num)));

   assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   assert_live_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_slot_valid & valid_plus) == '0));

   assert_slot0_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_offset[0 +: OFS_W] == '0));

   assert_reset_idle_R9: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
      assert_dead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_slot_valid[i]) |->
            (out_offset[i*OFS_W +: OFS_W] == '0 && !out_reg_we[i]
             && !out_mem_upd[i] && !out_pc_upd[i]));

      assert_regnum_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_reg_we[i]) |-> (out_reg_num[i*REG_W +: REG_W] == '0));

      if (i > 0) begin : g_grow
         assert_offset_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_slot_valid[i]) |->
               (out_offset[i*OFS_W +: OFS_W] > out_offset[(i-1)*OFS_W +: OFS_W]));
      end
   end

endmodule

bind hdr_scan_dispatch hdr_scan_checker #(
   .NUM_SLOTS (NUM_SLOTS),
   .OFS_W     (OFS_W)
) u_hdr_scan_checker (.*);

// File: tb/test_hdr_scan_dispatch.sv
module test_hdr_scan_dispatch;

   localparam int N   = 8;
   localparam int OW  = 9;
   localparam int RW  = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic [N*16-1:0] in_window = '0;
   logic           lead_valid, lead_reg_we, lead_mem_upd, lead_pc_upd;
   logic [RW-1:0]  lead_reg_num;
   logic           out_valid;
   logic           out_ready = 1'b1;
   logic [N-1:0]   out_slot_valid, out_reg_we, out_mem_upd, out_pc_upd;
   logic [N*OW-1:0] out_offset;
   logic [N*RW-1:0] out_reg_num;

   int tests_run = 0;
   int tests_failed = 0;
   logic [31:0] seed = 32'h1357_9bdf;

   always #2 clk = ~clk;

   hdr_scan_dispatch i_hdr_scan_dispatch (
      .clk, .rst_n, .in_valid, .in_ready, .in_window,
      .lead_valid, .lead_reg_we, .lead_reg_num, .lead_mem_upd, .lead_pc_upd,
      .out_valid, .out_ready, .out_slot_valid, .out_offset, .out_reg_we,
      .out_reg_num, .out_mem_upd, .out_pc_upd
   );

   // Reference model results
   logic [N-1:0]  e_valid, e_we, e_mem, e_pc;
   logic [OW-1:0] e_ofs  [N];
   logic [RW-1:0] e_rnum [N];

   function automatic logic [15:0] mk_hdr(int len, bit mem, bit pc, bit rwe, int rnum);
      logic [15:0] h;
      h = '0;
      h[15:10] = 6'(len);
      h[9] = mem;
      h[8] = pc;
      h[7] = rwe;
      h[4:0] = 5'(rnum);
      return h;
   endfunction

   function automatic logic [31:0] next_rand();
      logic [31:0] x;
      x = seed;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      seed = x;
      return x;
   endfunction

   task automatic ref_model(input logic [N*16-1:0] w);
      bit alive;
      int sum;
      alive = 1'b1;
      sum = 0;
      for (int i = 0; i < N; i++) begin
         int len;
         len = int'(w[i*16+10 +: 6]);
         if (len == 0) alive = 1'b0;
         e_valid[i] = alive;
         e_ofs[i]   = alive ? OW'(sum) : '0;
         e_we[i]    = alive & w[i*16+7];
         e_rnum[i]  = (alive & w[i*16+7]) ? w[i*16 +: 5] : '0;
         e_mem[i]   = alive & w[i*16+9];
         e_pc[i]    = alive & w[i*16+8];
         sum += len;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int got, input int exp);
      tests_run++;
      if (!ok) begin
         tests_failed++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic check_bundle(input logic [N*16-1:0] w, input string scen);
      ref_model(w);
      check(out_valid == 1'b1, "R7", {scen, " out_valid"}, int'(out_valid), 1);
      for (int i = 0; i < N; i++) begin
         check(out_slot_valid[i] == e_valid[i], "R3", $sformatf("%s slot %0d live", scen, i),
               int'(out_slot_valid[i]), int'(e_valid[i]));
         check(out_offset[i*OW +: OW] == e_ofs[i], "R2", $sformatf("%s slot %0d offset", scen, i),
               int'(out_offset[i*OW +: OW]), int'(e_ofs[i]));
         check({out_reg_we[i], out_mem_upd[i], out_pc_upd[i]} == {e_we[i], e_mem[i], e_pc[i]},
               "R1", $sformatf("%s slot %0d flags", scen, i),
               int'({out_reg_we[i], out_mem_upd[i], out_pc_upd[i]}),
               int'({e_we[i], e_mem[i], e_pc[i]}));
         check(out_reg_num[i*RW +: RW] == e_rnum[i], "R4", $sformatf("%s slot %0d regnum", scen, i),
               int'(out_reg_num[i*RW +: RW]), int'(e_rnum[i]));
      end
   endtask

   task automatic check_lead(input logic [N*16-1:0] w, input string scen);
      ref_model(w);
      check({lead_valid, lead_reg_we, lead_mem_upd, lead_pc_upd} ==
            {e_valid[0], e_we[0], e_mem[0], e_pc[0]}, "R6", {scen, " lead flags"},
            int'({lead_valid, lead_reg_we, lead_mem_upd, lead_pc_upd}),
            int'({e_valid[0], e_we[0], e_mem[0], e_pc[0]}));
      check(lead_reg_num == e_rnum[0], "R6", {scen, " lead regnum"},
            int'(lead_reg_num), int'(e_rnum[0]));
   endtask

   // Offer one window, check lead same cycle and bundle one cycle later
   task automatic send_and_check(input logic [N*16-1:0] w, input string scen);
      @(negedge clk);
      in_window = w;
      in_valid  = 1'b1;
      #1;
      check_lead(w, scen);
      @(negedge clk);
      in_valid = 1'b0;
      check_bundle(w, scen);
   endtask

   function automatic logic [N*16-1:0] rand_window(bit allow_zero, bit all_max);
      logic [N*16-1:0] w;
      for (int i = 0; i < N; i++) begin
         logic [31:0] r;
         int len;
         r = next_rand();
         if (all_max) len = 63;
         else if (allow_zero && r[31:29] == 3'd0) len = 0;
         else len = 1 + int'(r[15:10] % 6'd63);
         w[i*16 +: 16] = mk_hdr(len, r[9], r[8], r[7], int'(r[4:0]));
      end
      return w;
   endfunction

   task automatic t_reset();
      #1;
      check(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
      check(lead_valid == 1'b0, "R6", "lead idle", int'(lead_valid), 0);
   endtask

   task automatic t_layout_r1();
      logic [N*16-1:0] w;
      w[0*16 +: 16] = mk_hdr(3, 1, 0, 0, 17);
      w[1*16 +: 16] = mk_hdr(5, 0, 1, 0, 0);
      w[2*16 +: 16] = mk_hdr(1, 0, 0, 1, 31);
      w[3*16 +: 16] = mk_hdr(63, 1, 1, 1, 2);
      w[4*16 +: 16] = mk_hdr(2, 0, 0, 1, 0);
      w[5*16 +: 16] = mk_hdr(7, 1, 0, 1, 9);
      w[6*16 +: 16] = mk_hdr(4, 0, 1, 0, 30);
      w[7*16 +: 16] = mk_hdr(9, 0, 0, 0, 1);
      send_and_check(w, "R1 layout");
      check(out_offset[7*OW +: OW] == 9'd85, "R2", "slot 7 direct sum",
            int'(out_offset[7*OW +: OW]), 85);
   endtask

   task automatic t_random_r2();
      for (int k = 0; k < 40; k++)
         send_and_check(rand_window(1'b1, 1'b0), $sformatf("R2 random %0d", k));
   endtask

   task automatic t_all_max_r2();
      send_and_check(rand_window(1'b0, 1'b1), "R2 all max");
      check(out_offset[7*OW +: OW] == 9'd441, "R2", "max sum slot 7",
            int'(out_offset[7*OW +: OW]), 441);
   endtask

   task automatic t_terminator_r3();
      int spots[4] = '{0, 3, 7, 1};
      foreach (spots[s]) begin
         logic [N*16-1:0] w;
         w = rand_window(1'b0, 1'b0);
         w[spots[s]*16+10 +: 6] = '0;
         send_and_check(w, $sformatf("R3 term at %0d", spots[s]));
         check($countones(out_slot_valid) == spots[s], "R3", "live count",
               $countones(out_slot_valid), spots[s]);
      end
   endtask

   task automatic t_reserved_r5();
      logic [N*16-1:0] w, wr;
      w = rand_window(1'b0, 1'b0);
      wr = w;
      for (int i = 0; i < N; i++) wr[i*16+5 +: 2] = 2'b11;
      send_and_check(wr, "R5 reserved set");
      w[5*16+10 +: 6] = '0;
      wr = w;
      for (int i = 0; i < N; i++) wr[i*16+5 +: 2] = 2'(i);
      send_and_check(wr, "R5 reserved with terminator");
   endtask

   task automatic t_stall_r8();
      logic [N*16-1:0] wa, wb;
      wa = rand_window(1'b0, 1'b0);
      wb = rand_window(1'b0, 1'b0);
      @(negedge clk);
      out_ready = 1'b0;
      in_window = wa;
      in_valid  = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b0, "R8", "in_ready while stalled", int'(in_ready), 0);
      in_window = wb;
      @(negedge clk);
      @(negedge clk);
      check_bundle(wa, "R8 held");
      out_ready = 1'b1;
      #1;
      check(in_ready == 1'b1, "R8", "in_ready on consume", int'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
      check_bundle(wb, "R8 after release");
      @(negedge clk);
      check(out_valid == 1'b0, "R8", "drained", int'(out_valid), 0);
   endtask

   task automatic t_back_to_back_r10();
      logic [N*16-1:0] ws [4];
      for (int k = 0; k < 4; k++) ws[k] = rand_window(1'b1, 1'b0);
      out_ready = 1'b1;
      @(negedge clk);
      in_window = ws[0];
      in_valid  = 1'b1;
      for (int k = 1; k < 4; k++) begin
         @(negedge clk);
         check(in_ready == 1'b1, "R10", "in_ready streaming", int'(in_ready), 1);
         check_bundle(ws[k-1], $sformatf("R10 stream %0d", k - 1));
         in_window = ws[k];
      end
      @(negedge clk);
      in_valid = 1'b0;
      check_bundle(ws[3], "R10 stream 3");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests_failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_layout_r1();
      t_random_r2();
      t_all_max_r2();
      t_terminator_r3();
      t_reserved_r5();
      t_stall_r8();
      t_back_to_back_r10();
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule